// File: doc/BRIEF.md
# Converter Serial Control and Readout Port

This block is the device-side serial interface of a multi-channel data converter. A host shares one serial bus among several devices and talks to this one only while its active-low select line is low. A separate direction pin, not a command bit, decides what a transfer does. With that pin low, the host clocks an 8-bit control byte in on the data-in pin, and the byte chooses which input channel the converter samples next. With that pin high, the port sends the latest 10-bit conversion result back on a data-out line that has an output-enable, so that the line can float when the port is not sending.

The port also sends the conversion logic a one-cycle end-of-read strobe whenever the direction pin rises while the device is selected. All four bus pins are asynchronous to the block's system clock. Each pin passes through a synchronizer and an edge detector, and the rest of the logic runs on the system clock alone.

Top module: `conv_serial_port`

## Requirements
- R1: After a synchronous reset, the channel output is 0, the data-out enable is 0, data-out is 0 and the end-of-read strobe is 0.
- R2: While select is high, serial clock edges, data-in values and direction pin changes have no effect: the channel does not change, data-out stays disabled and no strobe is issued.
- R3: With select low and direction low, data-in is sampled on each rising serial clock edge, most significant bit first. On the 8th rising edge, byte bits [2:0] become the channel when their value is 0 to 4.
- R4: A completed control byte whose bits [2:0] hold 5, 6 or 7 leaves the channel at its previous value.
- R5: When select is low and direction is high, data-out is enabled and presents bit 9 of the result captured at that moment. Each falling serial clock edge then moves to the next lower bit.
- R6: After all 10 result bits have been presented, data-out drives 0 for every further falling edge until it is released.
- R7: The data-out enable drops on a falling direction edge or a rising select edge, whichever comes first.
- R8: A rising direction edge while select is low produces an end-of-read strobe that is high for exactly one system clock cycle.
- R9: A high select clears both bit counters, so a control byte cut short by select going high does not change the channel, and the next transfer starts at bit 7.
- R10: The result is captured once, when the read starts. Changes on the result input during a read do not alter the bits being shifted out.
- R11: Rising serial clock edges after the 8th in a write are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Bus select pin, active low (asynchronous) |
| ser_clk | input | 1 | Serial clock pin (asynchronous) |
| dir_rd | input | 1 | Direction pin: 1 read, 0 write (asynchronous) |
| ser_in | input | 1 | Serial data-in pin (asynchronous) |
| result_i | input | 10 | Latest conversion result |
| ser_out | output | 1 | Serial data-out value |
| ser_out_en | output | 1 | Data-out drive enable; 0 means the line floats |
| chan_o | output | 3 | Selected input channel |
| rd_done_o | output | 1 | End-of-read strobe, one clock cycle wide |

## Verification
Some states are reachable only through a particular order of pin changes. A read can be entered by raising the direction pin while the device stays selected, straight after a write, and that one edge both starts the read and fires the strobe. A transfer can also be cut short partway through a byte or a result. The stimulus steers the pins into these orders directly. It also moves the result input in the middle of a read, clocks past the last result bit, and sends control bytes longer than 8 bits. Between these directed cases come seeded random reads and writes that end either through the select pin or through the direction pin.

// File: rtl/conv_serial_port_pkg.sv
`timescale 1ns/1ps
// Package: shared constants for the converter serial port.
// Assumes: pins are packed into one vector in the bit order given here.
package conv_serial_port_pkg;
    localparam int PIN_N   = 4;
    localparam int PIN_DIN = 0;
    localparam int PIN_CLK = 1;
    localparam int PIN_DIR = 2;
    localparam int PIN_SEL = 3;
    // Idle level of each pin: select high, everything else low.
    localparam logic [PIN_N-1:0] PIN_IDLE = 4'b1000;
endpackage

// File: rtl/csp_pin_sync.sv
`timescale 1ns/1ps
// Module: csp_pin_sync
// Brings asynchronous pins into the clk domain and flags their edges.
// Assumes: every pin is slow compared with clk (several clk cycles per level).
module csp_pin_sync #(
    parameter int N = 4,
    parameter int STAGES = 2,
    parameter logic [N-1:0] IDLE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] level,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev;

    for (genvar g = 0; g < N; g++) begin : g_pin
        logic [STAGES-1:0] chain;
        // Shift chain for metastability settling of one pin.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{IDLE[g]}};
            else        chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign level[g] = chain[STAGES-1];
    end

    // One-cycle history of the settled levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= IDLE;
        else        prev <= level;
    end

    assign rise = level & ~prev;
    assign fall = ~level & prev;
endmodule

// File: rtl/csp_ctrl_shift.sv
`timescale 1ns/1ps
// Module: csp_ctrl_shift
// Receives the control byte MSB first and updates the channel register.
// Assumes: sample_en is a single-cycle pulse per rising serial clock in write mode.
module csp_ctrl_shift #(
    parameter int CTRL_W = 8,
    parameter int SEL_W  = 3,
    parameter int NUM_CH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             sample_en,
    input  logic             din,
    output logic [SEL_W-1:0] chan
);
    localparam int CNT_W = $clog2(CTRL_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CTRL_W - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(CTRL_W);
    localparam logic [SEL_W:0]   LIM  = (SEL_W + 1)'(NUM_CH);

    logic [CTRL_W-1:0] sh;
    logic [CNT_W-1:0]  cnt;
    logic [CTRL_W-1:0] byte_next;
    logic              load;

    assign byte_next = {sh[CTRL_W-2:0], din};
    assign load = sample_en && (cnt == LAST) && ({1'b0, byte_next[SEL_W-1:0]} < LIM);

    // Shift register and saturating bit counter, cleared while deselected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh  <= '0;
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (sample_en && cnt != FULL) begin
            sh  <= byte_next;
            cnt <= cnt + 1'b1;
        end
    end

    // Channel register updates only on a complete byte with a legal code.
    always_ff @(posedge clk) begin
        if (!rst_n)    chan <= '0;
        else if (load) chan <= byte_next[SEL_W-1:0];
    end

    p_chan_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, chan} < LIM);
    p_chan_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en == 1'b0) |=> $stable(chan));
    p_cnt_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt == '0));
    p_cnt_sat_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == FULL && !clear) |=> (cnt == FULL));
endmodule

// File: rtl/csp_data_shift.sv
`timescale 1ns/1ps
// Module: csp_data_shift
// Captures the result at read start and shifts it out MSB first, then zeros.
// Assumes: start and advance are single-cycle pulses and never coincide.
module csp_data_shift #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             start,
    input  logic             advance,
    input  logic [RES_W-1:0] result,
    output logic             bit_o
);
    localparam int CNT_W = $clog2(RES_W + 1);
    localparam logic [CNT_W-1:0] DONE = CNT_W'(RES_W);

    logic [RES_W-1:0] sh;
    logic [CNT_W-1:0] cnt;

    // Snapshot on start, shift in zeros on each falling serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh  <= '0;
            cnt <= '0;
        end else if (clear) begin
            sh  <= '0;
            cnt <= '0;
        end else if (start) begin
            sh  <= result;
            cnt <= '0;
        end else if (advance) begin
            sh  <= {sh[RES_W-2:0], 1'b0};
            if (cnt != DONE) cnt <= cnt + 1'b1;
        end
    end

    assign bit_o = sh[RES_W-1];

    p_zero_tail_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == DONE) |-> (bit_o == 1'b0));
    p_snap_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !advance && !clear) |=> $stable(bit_o));
endmodule

// File: rtl/conv_serial_port.sv
`timescale 1ns/1ps
// Module: conv_serial_port (top)
// Device-side serial port: control byte writes choose the channel, reads
// return the latest result on an enabled data-out line, and a rising direction
// pin while selected issues the end-of-read strobe.
// Assumes: bus pins are asynchronous and slower than clk; result_i is stable
// around the read start.
module conv_serial_port #(
    parameter int RES_W  = 10,
    parameter int CTRL_W = 8,
    parameter int SEL_W  = 3,
    parameter int NUM_CH = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_n,
    input  logic             ser_clk,
    input  logic             dir_rd,
    input  logic             ser_in,
    input  logic [RES_W-1:0] result_i,
    output logic             ser_out,
    output logic             ser_out_en,
    output logic [SEL_W-1:0] chan_o,
    output logic             rd_done_o
);
    import conv_serial_port_pkg::*;

    logic [PIN_N-1:0] pins_raw, lvl, rise, fall;
    logic s_sel_n, s_dir, selected, read_mode;
    logic drive_q, rd_start, rd_adv, wr_sample, shift_bit;

    assign pins_raw = {sel_n, dir_rd, ser_clk, ser_in};

    csp_pin_sync #(
        .N(PIN_N), .STAGES(SYNC_STAGES), .IDLE(PIN_IDLE)
    ) u_sync (
        .clk(clk), .rst_n(rst_n), .raw(pins_raw),
        .level(lvl), .rise(rise), .fall(fall)
    );

    assign s_sel_n   = lvl[PIN_SEL];
    assign s_dir     = lvl[PIN_DIR];
    assign selected  = !s_sel_n;
    assign read_mode = selected && s_dir;
    assign rd_start  = read_mode && !drive_q;
    assign rd_adv    = read_mode && drive_q && fall[PIN_CLK];
    assign wr_sample = selected && !s_dir && rise[PIN_CLK];

    // Output enable follows read mode, so whichever release edge comes first wins.
    always_ff @(posedge clk) begin
        if (!rst_n) drive_q <= 1'b0;
        else        drive_q <= read_mode;
    end

    // End-of-read strobe on a rising direction pin while selected.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_done_o <= 1'b0;
        else        rd_done_o <= rise[PIN_DIR] && selected;
    end

    csp_ctrl_shift #(
        .CTRL_W(CTRL_W), .SEL_W(SEL_W), .NUM_CH(NUM_CH)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .clear(s_sel_n),
        .sample_en(wr_sample), .din(lvl[PIN_DIN]), .chan(chan_o)
    );

    csp_data_shift #(
        .RES_W(RES_W)
    ) u_data (
        .clk(clk), .rst_n(rst_n), .clear(s_sel_n),
        .start(rd_start), .advance(rd_adv), .result(result_i), .bit_o(shift_bit)
    );

    assign ser_out    = drive_q ? shift_bit : 1'b0;
    assign ser_out_en = drive_q;

    p_float_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rise[PIN_SEL] |=> !ser_out_en);
    p_float_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fall[PIN_DIR] |=> !ser_out_en);
    p_strobe_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done_o |=> !rd_done_o);
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_sel_n && $past(s_sel_n)) |=> (!ser_out_en && !rd_done_o));
    p_out_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_out_en |-> !ser_out);
endmodule

// File: tb/conv_serial_port_bench.sv
`timescale 1ns/1ps
// Bench for conv_serial_port: seeded random transfers plus directed corners.
module conv_serial_port_bench;
    localparam int HP = 6;   // clk cycles per pin level change

    logic clk = 1'b0, rst_n = 1'b0;
    logic sel_n = 1'b1, ser_clk = 1'b0, dir_rd = 1'b0, ser_in = 1'b0;
    logic [9:0] result_i = '0;
    logic ser_out, ser_out_en, rd_done_o;
    logic [2:0] chan_o;
    int n_run = 0, n_fail = 0, strobes = 0;
    bit finished = 0;
    logic [2:0] exp_chan = 3'd0;

    always #10 clk = ~clk;

    conv_serial_port u_conv_serial_port (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .ser_clk(ser_clk),
        .dir_rd(dir_rd), .ser_in(ser_in), .result_i(result_i),
        .ser_out(ser_out), .ser_out_en(ser_out_en), .chan_o(chan_o),
        .rd_done_o(rd_done_o)
    );

    // Count strobe cycles away from the active edge.
    always @(negedge clk) if (rst_n && rd_done_o) strobes++;

    task automatic settle();
        repeat (HP) @(negedge clk);
    endtask

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] next_chan(logic [2:0] cur, logic [7:0] b);
        return (b[2:0] <= 3'd4) ? b[2:0] : cur;
    endfunction

    function automatic logic exp_bit(logic [9:0] r, int idx);
        return (idx < 10) ? r[9-idx] : 1'b0;
    endfunction

    // Clock nbits of val in MSB first with select low and direction low.
    task automatic write_bits(logic [15:0] val, int nbits, bit release_sel);
        sel_n = 1'b0; dir_rd = 1'b0; settle();
        for (int i = nbits - 1; i >= 0; i--) begin
            ser_in = val[i]; ser_clk = 1'b0; settle();
            ser_clk = 1'b1; settle();
        end
        ser_clk = 1'b0; settle();
        if (release_sel) begin sel_n = 1'b1; settle(); end
    endtask

    // Read with nfalls falling edges; result changed mid-read when disturb set.
    task automatic read_word(logic [9:0] r, int nfalls, bit via_dir, bit disturb, string req);
        result_i = r;
        if (via_dir) begin dir_rd = 1'b0; sel_n = 1'b0; settle(); dir_rd = 1'b1; end
        else begin sel_n = 1'b1; dir_rd = 1'b1; settle(); sel_n = 1'b0; end
        settle();
        check({req, " R5 enable"}, 16'(ser_out_en), 16'd1);
        check({req, " R5 msb"}, 16'(ser_out), 16'(exp_bit(r, 0)));
        for (int i = 1; i <= nfalls; i++) begin
            if (disturb && i == 3) result_i = ~r;
            ser_clk = 1'b1; settle();
            ser_clk = 1'b0; settle();
            check((i >= 10) ? {req, " R6 tail"} : (disturb ? {req, " R10 snap"} : {req, " R5 bit"}),
                  16'(ser_out), 16'(exp_bit(r, i)));
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_up();
    end

    initial begin
        int unsigned seed;
        int s0;
        seed = $urandom(32'd4242);
        repeat (4) @(negedge clk);
        rst_n = 1'b1; @(negedge clk);
        check("R1 chan", 16'(chan_o), 16'd0);
        check("R1 enable", 16'(ser_out_en), 16'd0);
        check("R1 dout", 16'(ser_out), 16'd0);
        check("R1 strobe", 16'(rd_done_o), 16'd0);

        // R3: legal byte loads channel.
        write_bits(16'h0A3, 8, 1); exp_chan = 3'd3;
        check("R3 chan", 16'(chan_o), 16'(exp_chan));
        // R4: codes 5..7 ignored.
        write_bits(16'h0F6, 8, 1);
        check("R4 chan", 16'(chan_o), 16'(exp_chan));
        write_bits(16'h004, 8, 1); exp_chan = 3'd4;
        check("R3 chan4", 16'(chan_o), 16'(exp_chan));

        // R2: activity while deselected.
        s0 = strobes;
        sel_n = 1'b1; dir_rd = 1'b0;
        for (int i = 0; i < 8; i++) begin
            ser_in = i[0]; ser_clk = 1'b1; settle(); ser_clk = 1'b0; settle();
        end
        dir_rd = 1'b1; settle();
        check("R2 enable", 16'(ser_out_en), 16'd0);
        dir_rd = 1'b0; settle();
        check("R2 chan", 16'(chan_o), 16'(exp_chan));
        check("R2 strobe", 16'(strobes - s0), 16'd0);

        // R9: aborted byte, then fresh byte.
        write_bits(16'h001, 5, 1);
        check("R9 abort", 16'(chan_o), 16'(exp_chan));
        write_bits(16'h002, 8, 1); exp_chan = 3'd2;
        check("R9 fresh", 16'(chan_o), 16'(exp_chan));

        // R11: 10 clocks; first 8 bits form 8'b0000_0001.
        write_bits(16'h007, 10, 1); exp_chan = 3'd1;
        check("R11 extra", 16'(chan_o), 16'(exp_chan));

        // R5/R6/R7: read, clock past the end, release by select.
        read_word(10'h2D5, 12, 0, 0, "d1");
        sel_n = 1'b1; settle();
        check("R7 sel release", 16'(ser_out_en), 16'd0);

        // R10 and R8: read entered by direction rise while selected.
        s0 = strobes;
        read_word(10'h1B3, 9, 1, 1, "d2");
        check("R8 one pulse", 16'(strobes - s0), 16'd1);
        dir_rd = 1'b0; settle();
        check("R7 dir release", 16'(ser_out_en), 16'd0);
        sel_n = 1'b1; settle();

        // Random mix.
        for (int it = 0; it < 30; it++) begin
            if ($urandom % 2 == 0) begin
                logic [7:0] b;
                b = 8'($urandom);
                write_bits(16'(b), 8, 1);
                exp_chan = next_chan(exp_chan, b);
                check("R3 rand", 16'(chan_o), 16'(exp_chan));
            end else begin
                logic [9:0] r;
                bit vd;
                r = 10'($urandom);
                vd = 1'($urandom);
                s0 = strobes;
                read_word(r, 10, vd, 0, "rand");
                if ($urandom % 2 == 0) dir_rd = 1'b0; else sel_n = 1'b1;
                settle();
                check("R7 rand", 16'(ser_out_en), 16'd0);
                check("R8 rand", 16'(strobes - s0), 16'(vd));
                sel_n = 1'b1; dir_rd = 1'b0; settle();
            end
        end
        finish_up();
    end
endmodule